// File: doc/BRIEF.md
# Decode-Stage Branch Verifier

This block sits at the exit of an instruction decoder. Each cycle it takes a bundle of up to `SLOTS` decoded instructions, which may belong to several hardware threads. It finds the branch mispredictions that can be settled without execution. The first kind is an instruction the front end predicted as taken that is not a control instruction at all. The second kind is a direct unconditional branch whose computed target disagrees with the predicted next address.

For every thread with such an offender, the block emits one redirect record for the fetch unit. The record carries the offender's sequence number and the corrected fetch addresses. Every younger instruction of that thread in the same bundle is dropped. The offender itself, and everything older or belonging to another thread, is passed on to the next stage one cycle later, in the same slot. Instructions that arrive already marked as squashed are discarded and counted. Instructions without source operands are tagged as ready to issue.

Top module: `dbv_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, no slot output is valid, no redirect is valid, and the drop count is zero.
- R2: A live input slot (valid and not marked squashed) that is not dropped appears in the same output slot one cycle later, with its thread id, sequence number and PC unchanged.
- R3: An input slot that is valid but marked squashed is never forwarded. The output drop count equals the number of valid input slots that were not forwarded in the previous cycle.
- R4: A forwarded instruction has its ready flag set exactly when its source-register count is zero.
- R5: A live instruction with the predicted-taken bit set and the control bit clear is an offender, and it produces a redirect for its thread.
- R6: A live control instruction that is both direct and unconditional is an offender when its computed target differs from its predicted PC. When the two are equal it is not an offender, and neither is an indirect or conditional control instruction.
- R7: A redirect record has mispredict = 1 and squash = 1. Its sequence number is the offender's, its next PC is the offender's computed target, its next-next PC is that target + 4, and its micro-PC is 0.
- R8: The redirect taken bit is 1 exactly when the offender's next PC differs from its PC + 4.
- R9: A redirect drops every live instruction of the same thread in the bundle whose sequence number is greater than the offender's. The offender is forwarded. Older instructions and those of other threads are unaffected.
- R10: At most one redirect is raised per thread per cycle. It comes from the offender with the smallest sequence number, regardless of slot position. Younger offenders are dropped and raise nothing.
- R11: A forwarded offender of the R6 kind carries its computed target as predicted PC and target + 4 as predicted next-next PC. Every other forwarded instruction carries its predicted PC unchanged and predicted PC + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | SLOTS | Slot holds an instruction |
| i_squashed | input | SLOTS | Instruction already marked squashed |
| i_tid | input | SLOTS x TID_W | Thread id |
| i_seq | input | SLOTS x SEQ_W | Sequence number (unique, no wrap) |
| i_pc | input | SLOTS x PC_W | Instruction address |
| i_npc | input | SLOTS x PC_W | Next address recorded by fetch |
| i_pred_taken | input | SLOTS | Front end predicted taken |
| i_pred_pc | input | SLOTS x PC_W | Predicted next fetch address |
| i_is_ctrl | input | SLOTS | Control instruction |
| i_is_direct | input | SLOTS | Direct (PC-relative) control |
| i_is_uncond | input | SLOTS | Unconditional control |
| i_target | input | SLOTS x PC_W | Computed branch target |
| i_nsrc | input | SLOTS x NSRC_W | Number of source registers |
| o_valid | output | SLOTS | Forwarded instruction present |
| o_tid | output | SLOTS x TID_W | Forwarded thread id |
| o_seq | output | SLOTS x SEQ_W | Forwarded sequence number |
| o_pc | output | SLOTS x PC_W | Forwarded address |
| o_pred_pc | output | SLOTS x PC_W | Predicted PC, corrected per R11 |
| o_pred_npc | output | SLOTS x PC_W | Predicted next-next PC |
| o_ready | output | SLOTS | No source operands |
| o_drop_cnt | output | CNT_W | Instructions dropped last cycle |
| o_rd_valid | output | THREADS | Redirect for that thread |
| o_rd_mispred | output | THREADS | Mispredict flag |
| o_rd_squash | output | THREADS | Squash flag |
| o_rd_taken | output | THREADS | Offender was taken |
| o_rd_seq | output | THREADS x SEQ_W | Offender sequence number |
| o_rd_npc | output | THREADS x PC_W | Corrected fetch address |
| o_rd_nnpc | output | THREADS x PC_W | Corrected fetch address + 4 |
| o_rd_upc | output | THREADS x UPC_W | Micro-PC, always zero |

## Verification
The bench builds the block with its defaults: four slots, two threads, 16-bit sequence numbers and 32-bit addresses. With four slots, one bundle can hold an offender, a younger victim of the same thread, a bystander of the other thread, and a second competing offender. With two threads, a single bundle can produce redirects for both threads at once. The directed bundles place offenders at slot positions that disagree with their sequence order, so the selection of the oldest offender by sequence number is exercised.

// File: rtl/dbv_pkg.sv
package dbv_pkg;
    localparam int INSN_BYTES = 4;

    typedef enum logic [1:0] {
        OFF_NONE      = 2'd0,
        OFF_NOT_CTRL  = 2'd1,
        OFF_BAD_TGT   = 2'd2
    } off_kind_e;
endpackage

// File: rtl/dbv_check.sv
module dbv_check
    import dbv_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            live,
    input  logic            pred_taken,
    input  logic            is_ctrl,
    input  logic            is_direct,
    input  logic            is_uncond,
    input  logic [PC_W-1:0] target,
    input  logic [PC_W-1:0] pred_pc,
    output off_kind_e       kind
);
    always_comb begin
        kind = OFF_NONE;
        if (live) begin
            if (pred_taken && !is_ctrl) begin
                kind = OFF_NOT_CTRL;
            end else if (is_ctrl && is_direct && is_uncond && (target != pred_pc)) begin
                kind = OFF_BAD_TGT;
            end
        end
    end
endmodule

// File: rtl/dbv_select.sv
module dbv_select #(
    parameter int SLOTS = 4,
    parameter int TID_W = 1,
    parameter int SEQ_W = 16
) (
    input  logic [SLOTS-1:0]            live,
    input  logic [SLOTS-1:0]            offend,
    input  logic [SLOTS-1:0][TID_W-1:0] tid,
    input  logic [SLOTS-1:0][SEQ_W-1:0] seq,
    output logic [SLOTS-1:0]            kill,
    output logic [SLOTS-1:0]            win
);
    always_comb begin
        for (int k = 0; k < SLOTS; k++) begin
            kill[k] = 1'b0;
            for (int j = 0; j < SLOTS; j++) begin
                if (j != k && offend[j] && live[k] &&
                    tid[j] == tid[k] && seq[j] < seq[k]) begin
                    kill[k] = 1'b1;
                end
            end
        end
        win = offend & ~kill;
    end
endmodule

// File: rtl/dbv_top.sv
module dbv_top
    import dbv_pkg::*;
#(
    parameter int SLOTS   = 4,
    parameter int THREADS = 2,
    parameter int SEQ_W   = 16,
    parameter int PC_W    = 32,
    parameter int NSRC_W  = 3,
    parameter int UPC_W   = 8,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SLOTS-1:0]              i_valid,
    input  logic [SLOTS-1:0]              i_squashed,
    input  logic [SLOTS-1:0][TID_W-1:0]   i_tid,
    input  logic [SLOTS-1:0][SEQ_W-1:0]   i_seq,
    input  logic [SLOTS-1:0][PC_W-1:0]    i_pc,
    input  logic [SLOTS-1:0][PC_W-1:0]    i_npc,
    input  logic [SLOTS-1:0]              i_pred_taken,
    input  logic [SLOTS-1:0][PC_W-1:0]    i_pred_pc,
    input  logic [SLOTS-1:0]              i_is_ctrl,
    input  logic [SLOTS-1:0]              i_is_direct,
    input  logic [SLOTS-1:0]              i_is_uncond,
    input  logic [SLOTS-1:0][PC_W-1:0]    i_target,
    input  logic [SLOTS-1:0][NSRC_W-1:0]  i_nsrc,
    output logic [SLOTS-1:0]              o_valid,
    output logic [SLOTS-1:0][TID_W-1:0]   o_tid,
    output logic [SLOTS-1:0][SEQ_W-1:0]   o_seq,
    output logic [SLOTS-1:0][PC_W-1:0]    o_pc,
    output logic [SLOTS-1:0][PC_W-1:0]    o_pred_pc,
    output logic [SLOTS-1:0][PC_W-1:0]    o_pred_npc,
    output logic [SLOTS-1:0]              o_ready,
    output logic [CNT_W-1:0]              o_drop_cnt,
    output logic [THREADS-1:0]            o_rd_valid,
    output logic [THREADS-1:0]            o_rd_mispred,
    output logic [THREADS-1:0]            o_rd_squash,
    output logic [THREADS-1:0]            o_rd_taken,
    output logic [THREADS-1:0][SEQ_W-1:0] o_rd_seq,
    output logic [THREADS-1:0][PC_W-1:0]  o_rd_npc,
    output logic [THREADS-1:0][PC_W-1:0]  o_rd_nnpc,
    output logic [THREADS-1:0][UPC_W-1:0] o_rd_upc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    typedef struct packed {
        logic               valid;
        logic               mispred;
        logic               squash;
        logic               taken;
        logic [SEQ_W-1:0]   seq;
        logic [PC_W-1:0]    npc;
        logic [PC_W-1:0]    nnpc;
        logic [UPC_W-1:0]   upc;
    } redir_t;

    typedef struct packed {
        logic [SLOTS-1:0]              valid;
        logic [SLOTS-1:0][TID_W-1:0]   tid;
        logic [SLOTS-1:0][SEQ_W-1:0]   seq;
        logic [SLOTS-1:0][PC_W-1:0]    pc;
        logic [SLOTS-1:0][PC_W-1:0]    pred_pc;
        logic [SLOTS-1:0][PC_W-1:0]    pred_npc;
        logic [SLOTS-1:0]              ready;
        logic [CNT_W-1:0]              drop;
        redir_t [THREADS-1:0]          rd;
    } state_t;

    state_t st_d, st_q;

    logic [SLOTS-1:0] live;
    logic [SLOTS-1:0] offend;
    logic [SLOTS-1:0] kill;
    logic [SLOTS-1:0] win;
    off_kind_e        kind [SLOTS];

    assign live = i_valid & ~i_squashed;

    for (genvar g = 0; g < SLOTS; g++) begin : g_chk
        dbv_check #(.PC_W(PC_W)) chk_i (
            .live       (live[g]),
            .pred_taken (i_pred_taken[g]),
            .is_ctrl    (i_is_ctrl[g]),
            .is_direct  (i_is_direct[g]),
            .is_uncond  (i_is_uncond[g]),
            .target     (i_target[g]),
            .pred_pc    (i_pred_pc[g]),
            .kind       (kind[g])
        );
        assign offend[g] = (kind[g] != OFF_NONE);
    end

    dbv_select #(
        .SLOTS (SLOTS),
        .TID_W (TID_W),
        .SEQ_W (SEQ_W)
    ) sel_i (
        .live   (live),
        .offend (offend),
        .tid    (i_tid),
        .seq    (i_seq),
        .kill   (kill),
        .win    (win)
    );

    always_comb begin
        st_d = '0;
        for (int k = 0; k < SLOTS; k++) begin
            logic keep;
            logic fix;
            keep = live[k] && !kill[k];
            fix  = win[k] && (kind[k] == OFF_BAD_TGT);
            st_d.valid[k] = keep;
            if (keep) begin
                st_d.tid[k]      = i_tid[k];
                st_d.seq[k]      = i_seq[k];
                st_d.pc[k]       = i_pc[k];
                st_d.pred_pc[k]  = fix ? i_target[k] : i_pred_pc[k];
                st_d.pred_npc[k] = (fix ? i_target[k] : i_pred_pc[k]) + STEP;
                st_d.ready[k]    = (i_nsrc[k] == '0);
            end
            if (i_valid[k] && !keep) begin
                st_d.drop = st_d.drop + CNT_W'(1);
            end
        end
        for (int t = 0; t < THREADS; t++) begin
            for (int k = 0; k < SLOTS; k++) begin
                if (win[k] && (int'(i_tid[k]) == t)) begin
                    st_d.rd[t].valid   = 1'b1;
                    st_d.rd[t].mispred = 1'b1;
                    st_d.rd[t].squash  = 1'b1;
                    st_d.rd[t].taken   = (i_npc[k] != i_pc[k] + STEP);
                    st_d.rd[t].seq     = i_seq[k];
                    st_d.rd[t].npc     = i_target[k];
                    st_d.rd[t].nnpc    = i_target[k] + STEP;
                    st_d.rd[t].upc     = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign o_valid    = st_q.valid;
    assign o_tid      = st_q.tid;
    assign o_seq      = st_q.seq;
    assign o_pc       = st_q.pc;
    assign o_pred_pc  = st_q.pred_pc;
    assign o_pred_npc = st_q.pred_npc;
    assign o_ready    = st_q.ready;
    assign o_drop_cnt = st_q.drop;

    for (genvar t = 0; t < THREADS; t++) begin : g_rd
        assign o_rd_valid[t]   = st_q.rd[t].valid;
        assign o_rd_mispred[t] = st_q.rd[t].mispred;
        assign o_rd_squash[t]  = st_q.rd[t].squash;
        assign o_rd_taken[t]   = st_q.rd[t].taken;
        assign o_rd_seq[t]     = st_q.rd[t].seq;
        assign o_rd_npc[t]     = st_q.rd[t].npc;
        assign o_rd_nnpc[t]    = st_q.rd[t].nnpc;
        assign o_rd_upc[t]     = st_q.rd[t].upc;
    end

    // Assertions
    p_fwd_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ($countones(o_valid) + int'(o_drop_cnt)) == $countones($past(i_valid)));

    logic [THREADS-1:0] rd_kept;
    always_comb begin
        for (int t = 0; t < THREADS; t++) begin
            rd_kept[t] = 1'b0;
            for (int k = 0; k < SLOTS; k++) begin
                if (o_valid[k] && int'(o_tid[k]) == t && o_seq[k] == o_rd_seq[t]) begin
                    rd_kept[t] = 1'b1;
                end
            end
        end
    end

    for (genvar t = 0; t < THREADS; t++) begin : g_rd_chk
        p_redirect_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
            o_rd_valid[t] |-> rd_kept[t]);
        p_record_r7: assert property (@(posedge clk) disable iff (!rst_n)
            o_rd_valid[t] |-> (o_rd_mispred[t] && o_rd_squash[t] &&
                               o_rd_nnpc[t] == o_rd_npc[t] + STEP && o_rd_upc[t] == '0));
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot_chk
        p_kill_younger_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (o_valid[k] && o_rd_valid[o_tid[k]]) |-> (o_seq[k] <= o_rd_seq[o_tid[k]]));
        p_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
            o_valid[k] |-> (o_ready[k] == ($past(i_nsrc[k]) == '0)));
    end
endmodule

// File: tb/dbv_top_tb_top.sv
`timescale 1ns/1ps
module dbv_top_tb_top;
    localparam int SLOTS = 4, THREADS = 2, SEQ_W = 16, PC_W = 32, NSRC_W = 3, UPC_W = 8;
    localparam int TID_W = 1, CNT_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [SLOTS-1:0]              i_valid, i_squashed, i_pred_taken, i_is_ctrl, i_is_direct, i_is_uncond;
    logic [SLOTS-1:0][TID_W-1:0]   i_tid;
    logic [SLOTS-1:0][SEQ_W-1:0]   i_seq;
    logic [SLOTS-1:0][PC_W-1:0]    i_pc, i_npc, i_pred_pc, i_target;
    logic [SLOTS-1:0][NSRC_W-1:0]  i_nsrc;
    logic [SLOTS-1:0]              o_valid, o_ready;
    logic [SLOTS-1:0][TID_W-1:0]   o_tid;
    logic [SLOTS-1:0][SEQ_W-1:0]   o_seq;
    logic [SLOTS-1:0][PC_W-1:0]    o_pc, o_pred_pc, o_pred_npc;
    logic [CNT_W-1:0]              o_drop_cnt;
    logic [THREADS-1:0]            o_rd_valid, o_rd_mispred, o_rd_squash, o_rd_taken;
    logic [THREADS-1:0][SEQ_W-1:0] o_rd_seq;
    logic [THREADS-1:0][PC_W-1:0]  o_rd_npc, o_rd_nnpc;
    logic [THREADS-1:0][UPC_W-1:0] o_rd_upc;

    dbv_top #(.SLOTS(SLOTS), .THREADS(THREADS), .SEQ_W(SEQ_W), .PC_W(PC_W),
              .NSRC_W(NSRC_W), .UPC_W(UPC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_squashed(i_squashed), .i_tid(i_tid),
        .i_seq(i_seq), .i_pc(i_pc), .i_npc(i_npc), .i_pred_taken(i_pred_taken),
        .i_pred_pc(i_pred_pc), .i_is_ctrl(i_is_ctrl), .i_is_direct(i_is_direct),
        .i_is_uncond(i_is_uncond), .i_target(i_target), .i_nsrc(i_nsrc),
        .o_valid(o_valid), .o_tid(o_tid), .o_seq(o_seq), .o_pc(o_pc), .o_pred_pc(o_pred_pc),
        .o_pred_npc(o_pred_npc), .o_ready(o_ready), .o_drop_cnt(o_drop_cnt),
        .o_rd_valid(o_rd_valid), .o_rd_mispred(o_rd_mispred), .o_rd_squash(o_rd_squash),
        .o_rd_taken(o_rd_taken), .o_rd_seq(o_rd_seq), .o_rd_npc(o_rd_npc),
        .o_rd_nnpc(o_rd_nnpc), .o_rd_upc(o_rd_upc)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // snapshot of the bundle the outputs under check were computed from
    logic [SLOTS-1:0]              p_v, p_sq, p_pt, p_ct, p_di, p_un;
    logic [SLOTS-1:0][TID_W-1:0]   p_tid;
    logic [SLOTS-1:0][SEQ_W-1:0]   p_seq;
    logic [SLOTS-1:0][PC_W-1:0]    p_pc, p_npc, p_ppc, p_tg;
    logic [SLOTS-1:0][NSRC_W-1:0]  p_ns;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic clear_in();
        i_valid = '0; i_squashed = '0; i_pred_taken = '0; i_is_ctrl = '0;
        i_is_direct = '0; i_is_uncond = '0; i_tid = '0; i_seq = '0; i_pc = '0;
        i_npc = '0; i_pred_pc = '0; i_target = '0; i_nsrc = '0;
    endtask

    task automatic put(input int k, input int tid, input int seq, input logic [31:0] pc,
                       input logic [31:0] npc, input bit pt, input logic [31:0] ppc,
                       input bit ct, input bit di, input bit un, input logic [31:0] tg,
                       input int ns, input bit sq);
        i_valid[k] = 1'b1; i_tid[k] = TID_W'(tid); i_seq[k] = SEQ_W'(seq); i_pc[k] = pc;
        i_npc[k] = npc; i_pred_taken[k] = pt; i_pred_pc[k] = ppc; i_is_ctrl[k] = ct;
        i_is_direct[k] = di; i_is_uncond[k] = un; i_target[k] = tg;
        i_nsrc[k] = NSRC_W'(ns); i_squashed[k] = sq;
    endtask

    // Behavioural reference: evaluate the snapshot and compare all outputs.
    task automatic compare();
        int win_seq [THREADS];
        int win_k [THREADS];
        bit off [SLOTS];
        bit bad [SLOTS];
        int drop = 0;
        for (int t = 0; t < THREADS; t++) begin win_seq[t] = -1; win_k[t] = -1; end
        for (int k = 0; k < SLOTS; k++) begin
            bit live;
            live = p_v[k] && !p_sq[k];
            bad[k] = live && !(p_pt[k] && !p_ct[k]) && p_ct[k] && p_di[k] && p_un[k] && (p_tg[k] != p_ppc[k]);
            off[k] = (live && p_pt[k] && !p_ct[k]) || bad[k];
            if (off[k] && (win_seq[p_tid[k]] < 0 || int'(p_seq[k]) < win_seq[p_tid[k]])) begin
                win_seq[p_tid[k]] = int'(p_seq[k]);
                win_k[p_tid[k]] = k;
            end
        end
        for (int k = 0; k < SLOTS; k++) begin
            bit keep;
            keep = p_v[k] && !p_sq[k] &&
                   !(win_seq[p_tid[k]] >= 0 && int'(p_seq[k]) > win_seq[p_tid[k]]);
            if (p_v[k] && !keep) drop++;
            chk($sformatf("R9 R3 slot%0d valid", k), 64'(o_valid[k]), 64'(keep));
            if (keep && o_valid[k]) begin
                logic [31:0] eppc;
                eppc = (win_k[p_tid[k]] == k && bad[k]) ? p_tg[k] : p_ppc[k];
                chk($sformatf("R2 slot%0d tid", k), 64'(o_tid[k]), 64'(p_tid[k]));
                chk($sformatf("R2 slot%0d seq", k), 64'(o_seq[k]), 64'(p_seq[k]));
                chk($sformatf("R2 slot%0d pc", k), 64'(o_pc[k]), 64'(p_pc[k]));
                chk($sformatf("R11 slot%0d pred_pc", k), 64'(o_pred_pc[k]), 64'(eppc));
                chk($sformatf("R11 slot%0d pred_npc", k), 64'(o_pred_npc[k]), 64'(eppc + 32'd4));
                chk($sformatf("R4 slot%0d ready", k), 64'(o_ready[k]), 64'(p_ns[k] == 0));
            end
        end
        chk("R3 drop count", 64'(o_drop_cnt), 64'(drop));
        for (int t = 0; t < THREADS; t++) begin
            chk($sformatf("R5 R6 R10 thread%0d redirect", t), 64'(o_rd_valid[t]), 64'(win_k[t] >= 0));
            if (win_k[t] >= 0 && o_rd_valid[t]) begin
                int w;
                w = win_k[t];
                chk("R7 mispred", 64'(o_rd_mispred[t]), 64'd1);
                chk("R7 squash", 64'(o_rd_squash[t]), 64'd1);
                chk("R7 R10 seq", 64'(o_rd_seq[t]), 64'(p_seq[w]));
                chk("R7 npc", 64'(o_rd_npc[t]), 64'(p_tg[w]));
                chk("R7 nnpc", 64'(o_rd_nnpc[t]), 64'(p_tg[w] + 32'd4));
                chk("R7 upc", 64'(o_rd_upc[t]), 64'd0);
                chk("R8 taken", 64'(o_rd_taken[t]), 64'(p_npc[w] != p_pc[w] + 32'd4));
            end
        end
    endtask

    // Hold the current bundle over one rising edge, then compare and clear.
    task automatic step();
        p_v = i_valid; p_sq = i_squashed; p_pt = i_pred_taken; p_ct = i_is_ctrl;
        p_di = i_is_direct; p_un = i_is_uncond; p_tid = i_tid; p_seq = i_seq;
        p_pc = i_pc; p_npc = i_npc; p_ppc = i_pred_pc; p_tg = i_target; p_ns = i_nsrc;
        @(negedge clk);
        compare();
        clear_in();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seqc;
        clear_in();
        repeat (3) @(negedge clk);
        // R1: outputs idle under reset
        chk("R1 valid in reset", 64'(o_valid), 64'd0);
        chk("R1 redirect in reset", 64'(o_rd_valid), 64'd0);
        chk("R1 drop in reset", 64'(o_drop_cnt), 64'd0);
        rst_n = 1'b1;
        step();  // R1: first cycle after reset (empty snapshot)

        // R2 R4: clean bundle, two threads, mixed operand counts
        put(0, 0, 10, 32'h100, 32'h104, 0, 32'h104, 0, 0, 0, 32'h0, 0, 0);
        put(1, 1, 11, 32'h200, 32'h204, 0, 32'h204, 0, 0, 0, 32'h0, 2, 0);
        put(2, 0, 12, 32'h104, 32'h108, 0, 32'h108, 1, 1, 1, 32'h108, 1, 0);
        put(3, 1, 13, 32'h204, 32'h300, 1, 32'h300, 1, 0, 1, 32'h999, 0, 0);
        step();

        // R3: squashed arrivals are dropped and counted
        put(0, 0, 20, 32'h110, 32'h114, 0, 32'h114, 0, 0, 0, 0, 1, 1);
        put(1, 0, 21, 32'h114, 32'h118, 0, 32'h118, 0, 0, 0, 0, 1, 0);
        put(3, 1, 22, 32'h210, 32'h214, 1, 32'h400, 0, 0, 0, 32'h500, 1, 1);
        step();

        // R5 R9: false taken in slot1 of thread0; slot2 younger thread0 dropped, slot3 other thread kept
        put(0, 0, 30, 32'h120, 32'h124, 0, 32'h124, 0, 0, 0, 0, 1, 0);
        put(1, 0, 31, 32'h124, 32'h124, 1, 32'h800, 0, 0, 0, 32'h128, 1, 0);
        put(2, 0, 32, 32'h128, 32'h12c, 0, 32'h12c, 0, 0, 0, 0, 0, 0);
        put(3, 1, 33, 32'h220, 32'h224, 0, 32'h224, 0, 0, 0, 0, 0, 0);
        step();

        // R6 R7 R8 R11: wrong direct target on both threads, taken and not taken
        put(0, 1, 40, 32'h230, 32'h234, 0, 32'h234, 1, 1, 1, 32'h600, 0, 0);
        put(1, 0, 41, 32'h130, 32'h700, 1, 32'h700, 1, 1, 1, 32'h740, 0, 0);
        put(2, 1, 42, 32'h234, 32'h238, 0, 32'h238, 0, 0, 0, 0, 0, 0);
        put(3, 0, 43, 32'h134, 32'h138, 0, 32'h138, 0, 0, 0, 0, 0, 0);
        step();

        // R6: matching target, indirect and conditional mismatches raise nothing
        put(0, 0, 50, 32'h140, 32'h900, 1, 32'h900, 1, 1, 1, 32'h900, 0, 0);
        put(1, 0, 51, 32'h900, 32'h904, 0, 32'h904, 1, 0, 1, 32'hA00, 0, 0);
        put(2, 1, 52, 32'h240, 32'h244, 0, 32'h244, 1, 1, 0, 32'hB00, 0, 0);
        step();

        // R10: offenders out of slot order; lower sequence number wins
        put(0, 0, 65, 32'h150, 32'h154, 1, 32'h999, 0, 0, 0, 32'h154, 0, 0);
        put(1, 0, 63, 32'h158, 32'h15c, 0, 32'h15c, 1, 1, 1, 32'hC00, 0, 0);
        put(2, 0, 64, 32'h15c, 32'h160, 0, 32'h160, 0, 0, 0, 0, 0, 0);
        put(3, 0, 60, 32'h14c, 32'h150, 0, 32'h150, 0, 0, 0, 0, 0, 0);
        step();

        // R10: squashed offender does not compete
        put(0, 1, 70, 32'h260, 32'h264, 1, 32'hDD0, 0, 0, 0, 32'h264, 0, 1);
        put(1, 1, 71, 32'h264, 32'h268, 1, 32'hDE0, 0, 0, 0, 32'h268, 0, 0);
        put(2, 1, 72, 32'h268, 32'h26c, 0, 32'h26c, 0, 0, 0, 0, 0, 0);
        step();

        // Randomized bundles, all requirements via the reference model
        seqc = 100;
        for (int n = 0; n < 400; n++) begin
            for (int k = 0; k < SLOTS; k++) begin
                if ($urandom_range(0, 4) != 0) begin
                    logic [31:0] pc, ppc, tg;
                    bit ct;
                    pc = {$urandom_range(0, 255), 2'b00};
                    ppc = ($urandom_range(0, 1) != 0) ? pc + 32'd4 : {$urandom_range(0, 255), 2'b00};
                    tg = ($urandom_range(0, 2) != 0) ? ppc : {$urandom_range(0, 255), 2'b00};
                    ct = $urandom_range(0, 1);
                    put(k, $urandom_range(0, 1), seqc + $urandom_range(0, 3) * 8, pc,
                        ($urandom_range(0, 1) != 0) ? pc + 32'd4 : ppc,
                        ($urandom_range(0, 5) == 0), ppc, ct, $urandom_range(0, 1),
                        $urandom_range(0, 1), tg, $urandom_range(0, 3), ($urandom_range(0, 7) == 0));
                    seqc++;
                end
            end
            seqc += 40;
            step();
        end
        step();

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule